// File: doc/BRIEF.md
# Entropy Collector Startup Sequencer

This block sequences the startup phase of a true random number generator. Software programs a 32-bit control word through a small write/read port. The word holds a scaled sample count, an enable, a test-mode switch and a feedback-bypass switch. While the block is enabled, it feeds the XOR of a set of oscillator sample bits into a wide shift register with XNOR feedback. It does this once per clock until the programmed number of samples has been taken, and then it raises a ready flag.

In test mode the shift register is cleared on entry and can then be seeded word by word. The bypass switch turns the register into a plain shift register that takes in the raw combined oscillator bit on every clock. A need-clock status output tells the clock controller whether the block still needs its clock.

Top module: `entropy_seq_top`

## Requirements
- R1: After reset, the control word reads 0, ready and need_clock are 0, and the shift register is all zeros.
- R2: The control word uses these bit positions: enable at bit 10, bypass at bit 2, test mode at bit 1, and the scaled count field at bits 16 upward, CFG_W bits wide. Every other bit reads 0 whatever was written.
- R3: A control write changes the count field only if enable was 0 before the write. This holds also for a write that clears enable at the same time.
- R4: The ready flag first reads 1 exactly T clock edges after the edge that stores enable=1. T is N·2^SCALE_W for a nonzero field N, and 2^(CFG_W+SCALE_W) for N=0.
- R5: The bypass bit is stored as 1 only when the same write also sets test mode. In every other case it reads 0.
- R6: The edge that turns test mode on clears the shift register. Shift-register word writes (address 1 = bits 31:0, 2 = bits 63:32, 3 = bits 79:64 zero-extended) take effect only while test mode is on. Outside test mode they are ignored.
- R7: need_clock is 1 whenever test mode is on. Outside test mode it is 1 while the startup count is running and 0 otherwise.
- R8: Clearing enable drops ready and need_clock by the next edge and resets the count, so a later enable runs the full count again.
- R9: During the startup count, each edge shifts the register left by one and puts x ^ ~(s[79]^s[78]^s[42]^s[41]) into bit 0, where x is the XOR of all oscillator inputs.
- R10: While bypass is 1, each edge shifts x into bit 0 with no feedback, even when enable is 0.
- R11: With bypass 0, the shift register holds its value once the count has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected address |
| addr | input | ADDR_W (2) | 0 = control word, 1..3 = shift-register words |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| osc_bits | input | NUM_OSC | Oscillator sample bits |
| ready | output | 1 | Startup count complete |
| need_clock | output | 1 | Block still needs its clock |
| sr_state | output | SR_W | Shift register contents |

## Verification
The bench builds the block with CFG_W=4, SCALE_W=2 and NUM_OSC=4, and keeps the 80-bit register with its default taps. This shrinks the count field to 16 codes, so every field value can be swept, including the zero code that means 64 samples, and each measured ready latency can be compared with the arithmetic value. The full-width register stays in place, so the bench can check feedback shifting, bypass shifting, seeding and the zero-extended top word against a bench-side step function.

// File: rtl/entropy_seq_pkg.sv
// Package: control word bit positions and address map shared by the
// sequencer modules. Assumes a 32-bit register port.
package entropy_seq_pkg;
    localparam int WORD_W    = 32;
    localparam int EN_BIT    = 10;
    localparam int BYP_BIT   = 2;
    localparam int TEST_BIT  = 1;
    localparam int FIELD_LSB = 16;
    localparam int CTRL_ADDR = 0;
endpackage

// File: rtl/entropy_ctrl_regs.sv
// Control register: holds enable, test mode, bypass and the scaled count
// field. Assumes the top has already decoded a control-word write.
module entropy_ctrl_regs #(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_en_bit,
    input  logic             wr_test_bit,
    input  logic             wr_byp_bit,
    input  logic [CFG_W-1:0] wr_field,
    output logic             en_q,
    output logic             test_q,
    output logic             bypass_q,
    output logic [CFG_W-1:0] field_q,
    output logic             test_entry
);
    // Rising test mode as seen by the write being accepted this cycle.
    assign test_entry = wr_ctrl & wr_test_bit & ~test_q;

    // Update flags on a control write; the field is locked while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            test_q   <= 1'b0;
            bypass_q <= 1'b0;
            field_q  <= '0;
        end else if (wr_ctrl) begin
            en_q     <= wr_en_bit;
            test_q   <= wr_test_bit;
            bypass_q <= wr_byp_bit & wr_test_bit;
            if (!en_q) begin
                field_q <= wr_field;
            end
        end
    end

    p_field_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(field_q));

    p_bypass_needs_test_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_q |-> test_q);
endmodule

// File: rtl/entropy_startup_cnt.sv
// Startup sample counter: counts samples taken while enabled and raises
// done at the programmed total. A zero field selects the maximum total.
// Assumes the field is stable while enable is high.
module entropy_startup_cnt #(
    parameter int CFG_W   = 16,
    parameter int SCALE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CFG_W-1:0] field,
    output logic             done,
    output logic             counting
);
    localparam int CNT_W = CFG_W + SCALE_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;

    // Decode the scaled count, zero meaning the largest total.
    always_comb begin
        if (field == '0) begin
            target = CNT_W'(1) << (CFG_W + SCALE_W);
        end else begin
            target = CNT_W'(field) << SCALE_W;
        end
    end

    assign counting = en & ~done;

    // Count one sample per cycle until the target is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == target - CNT_W'(1)) begin
                done <= 1'b1;
            end
        end
    end

    p_done_at_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(cnt) == target - CNT_W'(1)));

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (cnt < target));

    p_idle_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0 && !done));
endmodule

// File: rtl/entropy_shift_reg.sv
// Main entropy shift register: XNOR-feedback shifting of the combined
// oscillator bit, a plain-shift bypass, clear on test entry and word loads.
// Assumes clear, word write and sampling are prioritised in that order.
module entropy_shift_reg #(
    parameter int SR_W    = 80,
    parameter int NUM_OSC = 8,
    parameter int TAP_A   = 80,
    parameter int TAP_B   = 79,
    parameter int TAP_C   = 43,
    parameter int TAP_D   = 42,
    parameter int NWORDS  = 3,
    parameter int WSEL_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OSC-1:0] osc_bits,
    input  logic               sample_en,
    input  logic               bypass,
    input  logic               clear,
    input  logic               wr_word,
    input  logic [WSEL_W-1:0]  word_sel,
    input  logic [31:0]        wdata,
    output logic [SR_W-1:0]    sr_q
);
    localparam int PAD_W = NWORDS * 32;

    logic            in_bit;
    logic            fb_bit;
    logic [PAD_W-1:0] loaded;

    // Combine the oscillator samples and the tap feedback.
    assign fb_bit = ~(sr_q[TAP_A-1] ^ sr_q[TAP_B-1] ^ sr_q[TAP_C-1] ^ sr_q[TAP_D-1]);
    assign in_bit = bypass ? (^osc_bits) : ((^osc_bits) ^ fb_bit);

    // Overlay one 32-bit word on the current contents for a seed load.
    always_comb begin
        loaded = PAD_W'(sr_q);
        loaded[32*int'(word_sel) +: 32] = wdata;
    end

    // Clear, load or shift the register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr_q <= '0;
        end else if (wr_word) begin
            sr_q <= loaded[SR_W-1:0];
        end else if (sample_en) begin
            sr_q <= {sr_q[SR_W-2:0], in_bit};
        end
    end

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sr_q == '0));

    p_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !clear && !wr_word) |=> (sr_q[SR_W-1:1] == $past(sr_q[SR_W-2:0])));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !clear && !wr_word) |=> $stable(sr_q));
endmodule

// File: rtl/entropy_seq_top.sv
// Top of the entropy startup sequencer: decodes the register port, ties
// the control register, startup counter and shift register together and
// forms ready / need_clock. Assumes SR_W fits in NWORDS 32-bit words.
module entropy_seq_top
    import entropy_seq_pkg::*;
#(
    parameter int SR_W    = 80,
    parameter int NUM_OSC = 8,
    parameter int CFG_W   = 16,
    parameter int SCALE_W = 8,
    parameter int TAP_A   = 80,
    parameter int TAP_B   = 79,
    parameter int TAP_C   = 43,
    parameter int TAP_D   = 42,
    localparam int NWORDS = (SR_W + 31) / 32,
    localparam int ADDR_W = $clog2(NWORDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_OSC-1:0] osc_bits,
    output logic               ready,
    output logic               need_clock,
    output logic [SR_W-1:0]    sr_state
);
    localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int PAD_W  = NWORDS * 32;

    logic             wr_ctrl;
    logic             wr_word;
    logic             en_q;
    logic             test_q;
    logic             bypass_q;
    logic [CFG_W-1:0] field_q;
    logic             test_entry;
    logic             done;
    logic             counting;
    logic [WSEL_W-1:0] word_sel;
    logic [PAD_W-1:0] sr_pad;

    // Address decode for the control word and the seed words.
    assign wr_ctrl  = wr_en && (int'(addr) == CTRL_ADDR);
    assign wr_word  = wr_en && test_q && (int'(addr) != CTRL_ADDR) && (int'(addr) <= NWORDS);
    assign word_sel = WSEL_W'(addr - ADDR_W'(1));

    entropy_ctrl_regs #(.CFG_W(CFG_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_en_bit  (wdata[EN_BIT]),
        .wr_test_bit(wdata[TEST_BIT]),
        .wr_byp_bit (wdata[BYP_BIT]),
        .wr_field   (wdata[FIELD_LSB +: CFG_W]),
        .en_q       (en_q),
        .test_q     (test_q),
        .bypass_q   (bypass_q),
        .field_q    (field_q),
        .test_entry (test_entry)
    );

    entropy_startup_cnt #(.CFG_W(CFG_W), .SCALE_W(SCALE_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .field   (field_q),
        .done    (done),
        .counting(counting)
    );

    entropy_shift_reg #(
        .SR_W   (SR_W),
        .NUM_OSC(NUM_OSC),
        .TAP_A  (TAP_A),
        .TAP_B  (TAP_B),
        .TAP_C  (TAP_C),
        .TAP_D  (TAP_D),
        .NWORDS (NWORDS),
        .WSEL_W (WSEL_W)
    ) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_bits (osc_bits),
        .sample_en(counting | bypass_q),
        .bypass   (bypass_q),
        .clear    (test_entry),
        .wr_word  (wr_word),
        .word_sel (word_sel),
        .wdata    (wdata),
        .sr_q     (sr_state)
    );

    // Status outputs.
    assign ready      = en_q & done;
    assign need_clock = test_q | counting;

    assign sr_pad = PAD_W'(sr_state);

    // Read mux: control word with reserved bits zero, or a register word.
    always_comb begin
        rdata = '0;
        if (int'(addr) == CTRL_ADDR) begin
            rdata[FIELD_LSB +: CFG_W] = field_q;
            rdata[EN_BIT]             = en_q;
            rdata[BYP_BIT]            = bypass_q;
            rdata[TEST_BIT]           = test_q;
        end else if (int'(addr) <= NWORDS) begin
            rdata = sr_pad[32*int'(word_sel) +: 32];
        end
    end

    p_need_clock_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !ready) |-> need_clock);

    p_ready_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[EN_BIT]) |=> !ready);
endmodule

// File: tb/test_entropy_seq_top.sv
`timescale 1ns/1ps
// Bench: sweeps every count code of a small configuration and checks
// shifting, seeding and status against values computed here.
module test_entropy_seq_top;
    localparam int CFG_W   = 4;
    localparam int SCALE_W = 2;
    localparam int NUM_OSC = 4;
    localparam int SR_W    = 80;
    localparam logic [31:0] EN   = 32'h0000_0400;
    localparam logic [31:0] TST  = 32'h0000_0002;
    localparam logic [31:0] BYP  = 32'h0000_0004;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               wr_en;
    logic [1:0]         addr;
    logic [31:0]        wdata;
    logic [31:0]        rdata;
    logic [NUM_OSC-1:0] osc_bits;
    logic               ready;
    logic               need_clock;
    logic [SR_W-1:0]    sr_state;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    entropy_seq_top #(
        .SR_W(SR_W), .NUM_OSC(NUM_OSC), .CFG_W(CFG_W), .SCALE_W(SCALE_W)
    ) i_entropy_seq_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .osc_bits(osc_bits), .ready(ready),
        .need_clock(need_clock), .sr_state(sr_state)
    );

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write is taken at the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [79:0] step(input logic [79:0] s, input logic x, input logic byp);
        logic nb;
        nb = byp ? x : (x ^ ~(s[79] ^ s[78] ^ s[42] ^ s[41]));
        return {s[78:0], nb};
    endfunction

    task automatic run_count(input int n, input string req);
        int k;
        int t;
        t = (n == 0) ? (1 << (CFG_W + SCALE_W)) : (n << SCALE_W);
        k = 0;
        while (!ready && k < 200) begin
            @(negedge clk);
            k++;
        end
        chk(k == t, req, 96'(k), 96'(t));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r, r1, r2, r3;
        logic [79:0] model;
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; osc_bits = 4'b0001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, r);
        chk(r == 32'h0, "R1 ctrl", 96'(r), 96'h0);
        chk(!ready && !need_clock, "R1 status", 96'({ready, need_clock}), 96'h0);
        chk(sr_state == '0, "R1 sr", 96'(sr_state), 96'h0);

        // R2/R5: all-ones write keeps only defined bits
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, r);
        chk(r == 32'h000F_0406, "R2 reserved", 96'(r), 96'h000F_0406);
        wr(2'd0, 32'h0);

        // R4/R7/R3/R8: sweep every count code
        for (int n = 0; n < 16; n++) begin
            wr(2'd0, 32'(n) << 16);
            wr(2'd0, (32'(n) << 16) | EN);
            chk(!ready && need_clock, "R7 running", 96'({ready, need_clock}), 96'h1);
            run_count(n, "R4 latency");
            chk(!need_clock, "R7 done", 96'(need_clock), 96'h0);
            wr(2'd0, (32'(n ^ 5) << 16) | EN);
            rd(2'd0, r);
            chk(r[19:16] == 4'(n), "R3 locked", 96'(r[19:16]), 96'(n));
            wr(2'd0, 32'(n ^ 5) << 16);
            rd(2'd0, r);
            chk(r[19:16] == 4'(n), "R3 locked on disable", 96'(r[19:16]), 96'(n));
            chk(!ready && !need_clock, "R8 idle", 96'({ready, need_clock}), 96'h0);
        end

        // R8: abort mid-count and restart runs the full count
        wr(2'd0, 32'h0003_0000);
        wr(2'd0, 32'h0003_0000 | EN);
        repeat (5) @(negedge clk);
        wr(2'd0, 32'h0003_0000);
        chk(!ready && !need_clock, "R8 abort", 96'({ready, need_clock}), 96'h0);
        wr(2'd0, 32'h0003_0000 | EN);
        run_count(3, "R8 restart");
        wr(2'd0, 32'h0);

        // R5: bypass without test is dropped
        wr(2'd0, BYP);
        rd(2'd0, r);
        chk(r == 32'h0, "R5 bypass w/o test", 96'(r), 96'h0);

        // R6: test entry clears the register
        wr(2'd0, TST);
        chk(sr_state == '0, "R6 clear on entry", 96'(sr_state), 96'h0);

        // R10: plain shifting with bypass, enable off
        wr(2'd0, TST | BYP);
        rd(2'd0, r);
        chk(r == 32'h6, "R5 bypass with test", 96'(r), 96'h6);
        model = '0;
        for (int i = 0; i < 40; i++) begin
            osc_bits = {3'b000, 1'(((i * 7 + 3) % 5) & 1)};
            @(negedge clk);
            model = step(model, osc_bits[0], 1'b1);
        end
        chk(sr_state == model, "R10 bypass shift", 96'(sr_state), 96'(model));
        osc_bits = 4'h0;
        wr(2'd0, TST);
        model = step(model, 1'b0, 1'b1);
        osc_bits = 4'h7;
        @(negedge clk);
        chk(sr_state == model, "R11 hold after bypass", 96'(sr_state), 96'(model));

        // R6: seed writes ignored outside test mode
        wr(2'd0, 32'h0);
        wr(2'd1, 32'hDEAD_BEEF);
        chk(sr_state == model, "R6 write ignored", 96'(sr_state), 96'(model));

        // R6: seed load in test mode and zero-extended top word
        wr(2'd0, TST);
        wr(2'd1, 32'h1234_5678);
        wr(2'd2, 32'h9ABC_DEF0);
        wr(2'd3, 32'hFFFF_A5A5);
        rd(2'd1, r1); rd(2'd2, r2); rd(2'd3, r3);
        chk({r3, r2, r1} == 96'h0000A5A5_9ABCDEF0_12345678, "R6 seed readback",
            {r3, r2, r1}, 96'h0000A5A5_9ABCDEF0_12345678);

        // R9: feedback shifting for 4 samples from the seed
        model = 80'hA5A5_9ABCDEF0_12345678;
        wr(2'd0, 32'h0001_0000 | EN | TST);
        for (int i = 0; i < 4; i++) begin
            osc_bits = 4'((i * 5 + 3) & 15);
            @(negedge clk);
            model = step(model, ^osc_bits, 1'b0);
        end
        chk(ready, "R4 ready in test", 96'(ready), 96'h1);
        chk(sr_state == model, "R9 feedback shift", 96'(sr_state), 96'(model));
        osc_bits = 4'h1;
        repeat (2) @(negedge clk);
        chk(sr_state == model, "R11 hold after done", 96'(sr_state), 96'(model));
        chk(need_clock, "R7 test holds need_clock", 96'(need_clock), 96'h1);
        wr(2'd0, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule